// File: doc/BRIEF.md
# Byte-Wide Asynchronous SRAM Access Controller

This block sits between a synchronous on-chip requester and an external byte-wide asynchronous static RAM with 131,072 locations (17 address bits, 8 data bits). The requester hands over one access at a time through a valid/ready handshake. Each access carries an address, write data and a write flag. Read results come back on a data output that is qualified by a one-cycle valid pulse.

On the memory side the controller drives the address and two chip selects of opposite polarity: an active-low select and an active-high select. It also drives an active-low output enable, an active-low write strobe, and a tri-state data bus. All memory timing is expressed in clock cycles. Each wait-state count is derived from a timing value in nanoseconds and the clock period parameter. The derivation is ceil(time / period), with a floor of one cycle. When no access is in progress, both selects sit at their deselect levels, so the memory rests in low-power standby.

An access runs through these phases:
- a setup cycle, where the address and selects are driven and no strobe is active;
- a strobe phase, with output enable low for a read or the write strobe low for a write;
- for writes only, a data hold cycle;
- a recovery phase that releases the bus and completes the minimum cycle time.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the memory is in standby. In this state `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1 and `mem_we_n`=1, and the controller does not drive `mem_dq`.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for exactly 1+RD+RR cycles for a read, or 1+WP+1+RW cycles for a write, and then returns high. The terms are: RD = max(ACC-1, OE, 1); RR = max(RC-1-RD, 1); RW = max(RC-2-WP, 1). ACC, OE, RC and WP are the wait counts of R9.
- R3: The memory is selected only with `mem_ce1_n`=0 together with `mem_ce2`=1. The two selects always change together.
- R4: The address and both selects are valid one cycle before `mem_oe_n` or `mem_we_n` falls. While selected, `mem_addr` equals the accepted request address and does not change.
- R5: During a read, `mem_oe_n` is low for exactly RD cycles and `mem_we_n` stays high. The data bus is sampled at the clock edge that ends the last of those cycles.
- R6: Read data appears on `rd_data` together with a single-cycle `rd_valid` pulse. The pulse falls in the last cycle in which `req_ready` is low.
- R7: During a write, `mem_we_n` is low for exactly WP cycles and `mem_oe_n` stays high. The request data is driven on `mem_dq` from the setup cycle through one cycle after `mem_we_n` rises. `mem_oe_n` and `mem_we_n` are never low at the same time.
- R8: The controller never drives `mem_dq` in a cycle where `mem_oe_n` is low. In the cycle in which `mem_oe_n` rises, the bus is left undriven.
- R9: The wait counts are computed as ceil(t/CLK_NS) with a minimum of 1, giving ACC from T_ACC_NS, OE from T_OE_NS, RC from T_RC_NS and WP from T_WP_NS. The defaults give ACC=7, OE=4, RC=7 and WP=5. Read data is therefore sampled no sooner than ACC cycles after the select and no sooner than OE cycles after output enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse qualifying `rd_data` |
| rd_data | output | 8 | Captured read data |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
Several properties are checked on every cycle:
- standby levels while ready;
- select-pair coherence;
- the setup cycle before each strobe;
- a stable address while selected;
- mutually exclusive strobes;
- no bus drive under output enable;
- the turnaround after a read;
- the data hold after a write;
- the single-cycle read-valid pulse.

Exact strobe widths, busy lengths and captured data can only be shown by the bench scenarios. The bench's memory model returns a poison byte until both the access and output-enable delays have elapsed, so any shortened wait state appears as wrong read data. A full sweep then writes and reads back every low-byte address.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state type and wait-state arithmetic for the SRAM controller.
// Assumes all timing values are given in whole nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_RD    = 3'd2,
        ST_WP    = 3'd3,
        ST_WH    = 3'd4,
        ST_REC   = 3'd5
    } seq_state_t;

    // Cycles needed to cover t_ns at a clock of clk_ns, never fewer than one.
    function automatic int unsigned wait_cycles(input int unsigned t_ns,
                                                input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Module: down-counting wait-state timer.
// Loaded with (cycles-1) on entry to a timed phase; done is high in the last cycle.
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
// Module: access sequencer for the SRAM controller.
// Walks idle -> setup -> strobe -> (hold) -> recovery and requests timer loads.
// Assumes the datapath has latched the write flag by the setup cycle.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int          CNT_W  = 4,
    parameter int unsigned RD_C   = 6,
    parameter int unsigned WP_C   = 5,
    parameter int unsigned REC_RD = 1,
    parameter int unsigned REC_WR = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             wr_q,
    input  logic             tmr_done,
    output seq_state_t       state,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture
);

    localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(RD_C - 1);
    localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(WP_C - 1);
    localparam logic [CNT_W-1:0] LD_RRD = CNT_W'(REC_RD - 1);
    localparam logic [CNT_W-1:0] LD_RWR = CNT_W'(REC_WR - 1);

    seq_state_t state_q, state_d;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RD) && tmr_done;
    assign state   = state_q;

    // Next-state and timer-load decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SETUP;
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (wr_q) begin
                    state_d = ST_WP;
                    tmr_val = LD_WP;
                end else begin
                    state_d = ST_RD;
                    tmr_val = LD_RD;
                end
            end
            ST_RD: if (tmr_done) begin
                state_d  = ST_REC;
                tmr_load = 1'b1;
                tmr_val  = LD_RRD;
            end
            ST_WP: if (tmr_done) state_d = ST_WH;
            ST_WH: begin
                state_d  = ST_REC;
                tmr_load = 1'b1;
                tmr_val  = LD_RWR;
            end
            ST_REC: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/sram_ctrl_dpath.sv
// Module: request latch and read-capture datapath.
// Holds the accepted address, data and direction for the whole access;
// captures the bus on the sequencer's capture strobe and pulses rd_valid.
module sram_ctrl_dpath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
        end
    end

    // Capture read data at the end of the strobe phase and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= bus_in;
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
// Module: top of the asynchronous SRAM controller.
// Converts single valid/ready requests into timed select/strobe sequences on a
// byte-wide asynchronous SRAM. Wait counts derive from ns timings and CLK_NS.
// Assumes one outstanding request and a board-level bus that floats when undriven.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          ADDR_W   = 17,
    parameter int          DATA_W   = 8,
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned T_ACC_NS = 70,
    parameter int unsigned T_OE_NS  = 35,
    parameter int unsigned T_RC_NS  = 70,
    parameter int unsigned T_WP_NS  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int unsigned ACC_C  = wait_cycles(T_ACC_NS, CLK_NS);
    localparam int unsigned OE_C   = wait_cycles(T_OE_NS, CLK_NS);
    localparam int unsigned RC_C   = wait_cycles(T_RC_NS, CLK_NS);
    localparam int unsigned WP_C   = wait_cycles(T_WP_NS, CLK_NS);
    localparam int unsigned RD_C   = umax(umax(ACC_C - 1, OE_C), 1);
    localparam int unsigned REC_RD = (RC_C > RD_C + 2) ? RC_C - 1 - RD_C : 1;
    localparam int unsigned REC_WR = (RC_C > WP_C + 3) ? RC_C - 2 - WP_C : 1;
    localparam int unsigned MAX_C  = umax(umax(RD_C, WP_C), umax(REC_RD, REC_WR));
    localparam int          CNT_W  = $clog2(MAX_C + 1);

    seq_state_t        state;
    logic              accept, tmr_load, tmr_done, capture;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q;
    logic              sel;
    logic              dq_oe;

    sram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctrl_seq #(
        .CNT_W  (CNT_W),
        .RD_C   (RD_C),
        .WP_C   (WP_C),
        .REC_RD (REC_RD),
        .REC_WR (REC_WR)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .wr_q      (wr_q),
        .tmr_done  (tmr_done),
        .state     (state),
        .accept    (accept),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .capture   (capture)
    );

    sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .capture   (capture),
        .bus_in    (mem_dq),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .wr_q      (wr_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // Pin decode from the sequencer state: select, strobes and bus drive.
    always_comb begin
        sel   = (state == ST_SETUP) || (state == ST_RD) ||
                (state == ST_WP)    || (state == ST_WH);
        dq_oe = wr_q && ((state == ST_SETUP) || (state == ST_WP) || (state == ST_WH));
    end

    assign req_ready = (state == ST_IDLE);
    assign mem_ce1_n = !sel;
    assign mem_ce2   = sel;
    assign mem_oe_n  = (state != ST_RD);
    assign mem_we_n  = (state != ST_WP);
    assign mem_addr  = addr_q;
    assign mem_dq    = dq_oe ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_ctrl_chk.sv
// Module: protocol checker for sram_ctrl, attached by bind.
// Observes the pins and the internal bus-drive enable.
module sram_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              dq_oe
);

    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !dq_oe));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_select_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce1_n == !mem_ce2);

    p_oe_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(!mem_ce1_n) && $stable(mem_addr)));

    p_we_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce1_n) && $stable(mem_addr)));

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

    p_rvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (dq_oe && !mem_ce1_n));

    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !mem_oe_n));

    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !dq_oe);

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .dq_oe     (dq_oe)
);

// File: tb/test_sram_ctrl.sv
// Bench: sweeps writes and reads over every low-byte address through a timed
// SRAM model that returns a poison byte until access and enable delays elapse.
module test_sram_ctrl;

    localparam int CK    = 10;
    localparam int ACC   = (70 + CK - 1) / CK;
    localparam int OEC   = (35 + CK - 1) / CK;
    localparam int RC    = (70 + CK - 1) / CK;
    localparam int WPC   = (50 + CK - 1) / CK;
    localparam int RDC   = ((ACC - 1) > OEC) ? ACC - 1 : OEC;
    localparam int RECR  = (RC - 1 - RDC) > 1 ? RC - 1 - RDC : 1;
    localparam int RECW  = (RC - 2 - WPC) > 1 ? RC - 2 - WPC : 1;
    localparam int BUSY_RD = 1 + RDC + RECR;
    localparam int BUSY_WR = 1 + WPC + 1 + RECW;
    localparam logic [7:0] POISON = 8'hEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;
    wire  [7:0]  mem_dq;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    sram_ctrl i_sram_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .mem_ce1_n (mem_ce1_n),
        .mem_ce2   (mem_ce2),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq    (mem_dq)
    );

    // Timed memory model indexed by the low address byte.
    logic [7:0] mdl [0:255];
    int         sel_cnt = 0;
    int         oe_cnt  = 0;
    logic       m_sel;
    assign m_sel = !mem_ce1_n && mem_ce2;

    initial for (int i = 0; i < 256; i++) mdl[i] = 8'h00;

    always @(posedge clk) begin
        sel_cnt <= m_sel ? sel_cnt + 1 : 0;
        oe_cnt  <= (m_sel && !mem_oe_n) ? oe_cnt + 1 : 0;
    end

    assign mem_dq = (m_sel && !mem_oe_n && mem_we_n)
                  ? ((sel_cnt >= ACC - 1 && oe_cnt >= OEC - 1) ? mdl[mem_addr[7:0]] : POISON)
                  : 8'hzz;

    always @(posedge mem_we_n)
        if (rst_n && m_sel) mdl[mem_addr[7:0]] <= mem_dq;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic check_idle(input string tag);
        chk(mem_ce1_n == 1'b1 && mem_ce2 == 1'b0, {tag, " R1 R3 standby selects"},
            {mem_ce1_n, mem_ce2}, 2);
        chk(mem_oe_n == 1'b1 && mem_we_n == 1'b1, {tag, " R1 strobes high"},
            {mem_oe_n, mem_we_n}, 3);
        chk(req_ready == 1'b1, {tag, " R1 ready"}, req_ready, 1);
    endtask

    // One access; samples every cycle at the falling edge while busy.
    task automatic run_req(input logic wr, input logic [16:0] a,
                           input logic [7:0] d, input logic [7:0] exp_rd);
        int busy, oe_lo, we_lo, rv_at, bad_addr, bad_pair;
        logic [7:0] got;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; oe_lo = 0; we_lo = 0; rv_at = -1; bad_addr = 0; bad_pair = 0; got = '0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (!mem_oe_n) oe_lo++;
            if (!mem_we_n) we_lo++;
            if (rd_valid) begin rv_at = busy; got = rd_data; end
            if (!mem_ce1_n && mem_addr !== a) bad_addr++;
            if (mem_ce1_n != !mem_ce2) bad_pair++;
            @(negedge clk);
        end
        chk(bad_addr == 0, "R4 address on pins while selected", bad_addr, 0);
        chk(bad_pair == 0, "R3 select pair coherent", bad_pair, 0);
        if (wr) begin
            chk(busy == BUSY_WR, "R2 R9 write busy length", busy, BUSY_WR);
            chk(we_lo == WPC, "R7 write strobe width", we_lo, WPC);
            chk(oe_lo == 0, "R7 output enable idle on write", oe_lo, 0);
            chk(rv_at == -1, "R6 no read valid on write", rv_at, -1);
        end else begin
            chk(busy == BUSY_RD, "R2 R9 read busy length", busy, BUSY_RD);
            chk(oe_lo == RDC, "R5 output enable width", oe_lo, RDC);
            chk(we_lo == 0, "R5 write strobe idle on read", we_lo, 0);
            chk(rv_at == BUSY_RD, "R6 read valid position", rv_at, BUSY_RD);
            chk(got == exp_rd, "R5 R9 read data", got, exp_rd);
        end
        chk(rd_valid == 1'b0, "R6 read valid single cycle", rd_valid, 0);
        check_idle("post-access");
    endtask

    function automatic logic [16:0] addr_of(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b ^ 8'h5A, b[0], b};
    endfunction

    function automatic logic [7:0] data_of(input int i);
        return 8'(i * 37 + 11);
    endfunction

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");
        // Fill every low-byte location, then read all back.
        for (int i = 0; i < 256; i++) run_req(1'b1, addr_of(i), data_of(i), 8'h00);
        for (int i = 0; i < 256; i++) run_req(1'b0, addr_of(i), 8'h00, data_of(i));
        // Overwrite then read immediately: write-to-read turnaround.
        for (int i = 0; i < 256; i += 17) begin
            run_req(1'b1, addr_of(i), ~data_of(i), 8'h00);
            run_req(1'b0, addr_of(i), 8'h00, ~data_of(i));
        end
        // Idle gaps keep standby levels.
        repeat (5) begin
            @(negedge clk);
            check_idle("idle gap");
        end
        summary();
        $finish;
    end

endmodule